// File: doc/BRIEF.md
# Way-Partitioned Cache Victim Selector

This block keeps the per-line tag state of a set-associative cache and decides which way receives a new line when a fill is needed. Each line has five pieces of state: valid, dirty, locked, a recently-used flag, and an address tag. Every requester has its own way-blocking mask. The requesters are a number of cores plus one shared hardware-agent slot. A requester may only evict from ways its mask leaves open, and never from a locked line.

Software-side agents issue one operation at a time. The operations are: an access (look up, then allocate on a miss), a lock (look up or allocate, then pin the line), a single-line flush, and a mask write. The block answers each operation with a hit flag, the way that was used, a write-back indication with the evicted line address, a no-allocate flag, and a success flag. The data array, the refill traffic and the write-back datapath live elsewhere.

The control is a three-state machine:
- `ST_IDLE`: accepts a request and moves to `ST_LOOK`.
- `ST_LOOK`: reads the addressed set, computes the result and the new set state, registers both, and moves to `ST_COMMIT`.
- `ST_COMMIT`: presents the response for one cycle, writes the set and any mask, and returns to `ST_IDLE`.

Top module: `waypart_victim_sel`

## Requirements
- R1: After reset every line is invalid, unlocked, clean and not recently used, and every mask is zero. While idle, `req_ready` is 1 and `resp_valid` is 0.
- R2: The address is split into a line offset (bits 6:0), a set index (the SET_BITS bits from bit 7) and a tag (the bits above the index). A valid line with a matching tag is a hit in any way, for any requester, whatever that requester's mask says. A hit returns `resp_hit`=1 and the way, and sets that line's used flag.
- R3: `req_op`=3 writes `req_mask` as the mask of `req_src`. Sources 0 to CORES-1 are cores and source CORES is the hardware agents. Bit i=1 blocks eviction from way i. An all-ones mask is rejected: `resp_ok`=0 and the stored mask is unchanged. Any other value is stored, with `resp_ok`=1.
- R4: On a miss with `req_op`=0 (access), the victim is the lowest-numbered eligible way that is invalid. A way is eligible when its mask bit is 0 and its line is unlocked.
- R5: If no eligible way is invalid, the victim is the lowest eligible way whose used flag is clear. If every eligible way has its used flag set, those flags are cleared and the lowest eligible way is chosen. A fill sets the used flag of the filled way.
- R6: A locked or masked way is never the victim. With no eligible way, the response has `resp_noalloc`=1 and `resp_ok`=0, and the set is left unchanged.
- R7: `req_write`=1 marks the accessed line dirty. An evicted line that was valid and dirty gives `resp_wb`=1, with `resp_wb_addr` set to its old line address.
- R8: `req_op`=1 (lock) hits or allocates as an access does. It is granted (`resp_ok`=1) only if the requester keeps at least one eligible way other than the target line. A line that is already locked is granted again. A refused lock leaves the line unlocked.
- R9: `req_op`=2 (flush) on a hit invalidates the line and clears its lock and dirty flags. It reports `resp_ok`=1 only if the line was locked, and `resp_wb`=1 if it was dirty. A flush that misses changes nothing and reports `resp_hit`=0 and `resp_ok`=0.
- R10: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the response has been given. `resp_valid` is high for exactly one cycle, two clock edges after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to accept |
| req_op | input | 2 | 0 access, 1 lock, 2 flush, 3 mask write |
| req_src | input | SRC_W (2) | Requester: core number, or CORES for hardware agents |
| req_addr | input | ADDR_W (32) | Physical address |
| req_write | input | 1 | Access is a store; marks the line dirty |
| req_mask | input | WAYS (4) | Mask value for a mask write |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Address found in the set |
| resp_way | output | WAY_W (2) | Hit or allocated way; 0 otherwise |
| resp_wb | output | 1 | Displaced or flushed line was dirty |
| resp_wb_addr | output | ADDR_W (32) | Line address to write back |
| resp_noalloc | output | 1 | Miss with no eligible way |
| resp_ok | output | 1 | Lock granted, locked line flushed, mask accepted, or access served |

## Verification
Tag, lock or used state that has gone wrong inside the block shows up at the ports on the next operation that reaches the same set. It appears as a different allocated way, a spurious or missing hit, or a wrong write-back flag, so it is visible within one request of being caused. A mask that is stored wrongly shows up on that requester's next miss, as a victim outside its open ways or as an unexpected no-allocate. The test sequence revisits each set right after every state-changing operation so that such errors surface at once.

// File: rtl/wpv_pkg.sv
package wpv_pkg;
    typedef enum logic [1:0] {
        OP_ACCESS = 2'd0,
        OP_LOCK   = 2'd1,
        OP_FLUSH  = 2'd2,
        OP_MASK   = 2'd3
    } wpv_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOK   = 2'd1,
        ST_COMMIT = 2'd2
    } wpv_state_e;
endpackage

// File: rtl/wpv_tag_array.sv
module wpv_tag_array #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int TAG_W = 21,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [WAYS-1:0]       rd_valid,
    output logic [WAYS-1:0]       rd_dirty,
    output logic [WAYS-1:0]       rd_lock,
    output logic [WAYS-1:0]       rd_used,
    output logic [WAYS*TAG_W-1:0] rd_tag,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [WAYS-1:0]       wr_valid,
    input  logic [WAYS-1:0]       wr_dirty,
    input  logic [WAYS-1:0]       wr_lock,
    input  logic [WAYS-1:0]       wr_used,
    input  logic [WAYS-1:0]       wr_tag_en,
    input  logic [TAG_W-1:0]      wr_tag
);
    logic [WAYS-1:0]  v_mem [SETS];
    logic [WAYS-1:0]  d_mem [SETS];
    logic [WAYS-1:0]  l_mem [SETS];
    logic [WAYS-1:0]  u_mem [SETS];
    logic [TAG_W-1:0] t_mem [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                v_mem[s] <= '0;
                d_mem[s] <= '0;
                l_mem[s] <= '0;
                u_mem[s] <= '0;
            end
        end else if (wr_en) begin
            v_mem[wr_idx] <= wr_valid;
            d_mem[wr_idx] <= wr_dirty;
            l_mem[wr_idx] <= wr_lock;
            u_mem[wr_idx] <= wr_used;
        end
    end

    // Tags need no reset: they are only compared under a valid bit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (wr_tag_en[w]) t_mem[wr_idx][w] <= wr_tag;
            end
        end
    end

    assign rd_valid = v_mem[rd_idx];
    assign rd_dirty = d_mem[rd_idx];
    assign rd_lock  = l_mem[rd_idx];
    assign rd_used  = u_mem[rd_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tag[w*TAG_W +: TAG_W] = t_mem[rd_idx][w];
    end
endmodule

// File: rtl/wpv_victim_pick.sv
module wpv_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  elig,
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  used,
    output logic             found,
    output logic [WAY_W-1:0] way,
    output logic [WAYS-1:0]  age
);
    function automatic logic [WAY_W-1:0] lowest(input logic [WAYS-1:0] vec);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (vec[i]) r = WAY_W'(i);
        end
        return r;
    endfunction

    logic [WAYS-1:0] free_w, fresh_w;

    always_comb begin
        free_w  = elig & ~valid;
        fresh_w = elig & ~used;
        found   = |elig;
        age     = '0;
        if (|free_w) begin
            way = lowest(free_w);
        end else if (|fresh_w) begin
            way = lowest(fresh_w);
        end else begin
            way = lowest(elig);
            age = elig;
        end
    end
endmodule

// File: rtl/wpv_mask_bank.sv
module wpv_mask_bank #(
    parameter int WAYS = 4,
    parameter int NSRC = 3,
    localparam int SRC_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SRC_W-1:0] wr_src,
    input  logic [WAYS-1:0]  wr_mask,
    output logic             accept,
    input  logic [SRC_W-1:0] rd_src,
    output logic [WAYS-1:0]  rd_mask
);
    logic [WAYS-1:0] mask_q [NSRC];

    assign accept = ~(&wr_mask);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)                                        mask_q[s] <= '0;
            else if (wr_en && accept && wr_src == SRC_W'(s))   mask_q[s] <= wr_mask;
        end
    end

    // Unused source codes fall back to the hardware-agent mask.
    assign rd_mask = (int'(rd_src) < NSRC) ? mask_q[rd_src] : mask_q[NSRC-1];
endmodule

// File: rtl/waypart_victim_sel.sv
module waypart_victim_sel
    import wpv_pkg::*;
#(
    parameter int WAYS      = 4,
    parameter int SET_BITS  = 4,
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 7,
    parameter int CORES     = 2,
    localparam int WAY_W = $clog2(WAYS),
    localparam int NSRC  = CORES + 1,
    localparam int SRC_W = $clog2(NSRC),
    localparam int TAG_W = ADDR_W - LINE_BITS - SET_BITS,
    localparam int SETS  = 1 << SET_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [WAYS-1:0]   req_mask,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WAY_W-1:0]  resp_way,
    output logic              resp_wb,
    output logic [ADDR_W-1:0] resp_wb_addr,
    output logic              resp_noalloc,
    output logic              resp_ok
);
    wpv_state_e state_q, state_d;

    wpv_op_e               op_q;
    logic [SRC_W-1:0]      src_q;
    logic [TAG_W-1:0]      tag_q;
    logic [SET_BITS-1:0]   idx_q;
    logic                  wr_q;
    logic [WAYS-1:0]       mask_q;

    // Offset bits are carried for completeness of the address only.
    logic unused_line_offset;
    assign unused_line_offset = ^req_addr[LINE_BITS-1:0];

    logic [WAYS-1:0]       rd_valid, rd_dirty, rd_lock, rd_used;
    logic [WAYS*TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]       cur_mask;
    logic                  mask_accept;

    logic [WAYS-1:0]  hit_vec, elig, age;
    logic             vic_found;
    logic [WAY_W-1:0] vic_way, hit_way;

    // next-set values and response computed in ST_LOOK
    logic [WAYS-1:0]   nv, nd, nl, nu, nte;
    logic              r_hit, r_wb, r_na, r_ok, r_alloc;
    logic [WAY_W-1:0]  r_way;
    logic [ADDR_W-1:0] r_wba;
    logic              grant;

    // registered copies presented in ST_COMMIT
    logic [WAYS-1:0]   wv_q, wd_q, wl_q, wu_q, wte_q, res_blk_q, res_lck_q;
    logic              res_hit_q, res_wb_q, res_na_q, res_ok_q, res_alloc_q;
    logic [WAY_W-1:0]  res_way_q;
    logic [ADDR_W-1:0] res_wba_q;

    wpv_tag_array #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk, .rst_n, .rd_idx(idx_q),
        .rd_valid, .rd_dirty, .rd_lock, .rd_used, .rd_tag,
        .wr_en(state_q == ST_COMMIT && op_q != OP_MASK), .wr_idx(idx_q),
        .wr_valid(wv_q), .wr_dirty(wd_q), .wr_lock(wl_q), .wr_used(wu_q),
        .wr_tag_en(wte_q), .wr_tag(tag_q)
    );

    wpv_mask_bank #(.WAYS(WAYS), .NSRC(NSRC)) u_masks (
        .clk, .rst_n,
        .wr_en(state_q == ST_COMMIT && op_q == OP_MASK), .wr_src(src_q),
        .wr_mask(mask_q), .accept(mask_accept),
        .rd_src(src_q), .rd_mask(cur_mask)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = rd_valid[w] && (rd_tag[w*TAG_W +: TAG_W] == tag_q);
    end

    always_comb begin
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
    end

    assign elig = ~cur_mask & ~rd_lock;

    wpv_victim_pick #(.WAYS(WAYS)) u_pick (
        .elig, .valid(rd_valid), .used(rd_used),
        .found(vic_found), .way(vic_way), .age
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOK;
            ST_LOOK:   state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Set update and result for the current request
    always_comb begin
        nv = rd_valid; nd = rd_dirty; nl = rd_lock; nu = rd_used; nte = '0;
        r_hit = 1'b0; r_way = '0; r_wb = 1'b0; r_wba = '0;
        r_na = 1'b0; r_ok = 1'b0; r_alloc = 1'b0; grant = 1'b0;
        unique case (op_q)
            OP_ACCESS, OP_LOCK: begin
                if (|hit_vec) begin
                    r_hit = 1'b1;
                    r_way = hit_way;
                    nu[hit_way] = 1'b1;
                    if (op_q == OP_ACCESS) begin
                        if (wr_q) nd[hit_way] = 1'b1;
                        r_ok = 1'b1;
                    end else begin
                        grant = rd_lock[hit_way] || |(elig & ~(WAYS'(1) << hit_way));
                        if (grant) nl[hit_way] = 1'b1;
                        r_ok = grant;
                    end
                end else if (vic_found) begin
                    r_alloc = 1'b1;
                    r_way   = vic_way;
                    if (rd_valid[vic_way] && rd_dirty[vic_way]) begin
                        r_wb  = 1'b1;
                        r_wba = {rd_tag[vic_way*TAG_W +: TAG_W], idx_q, {LINE_BITS{1'b0}}};
                    end
                    nu = rd_used & ~age;
                    nu[vic_way]  = 1'b1;
                    nv[vic_way]  = 1'b1;
                    nd[vic_way]  = wr_q;
                    nte[vic_way] = 1'b1;
                    grant = (op_q == OP_ACCESS) || |(elig & ~(WAYS'(1) << vic_way));
                    nl[vic_way]  = (op_q == OP_LOCK) && grant;
                    r_ok = grant;
                end else begin
                    r_na = 1'b1;
                end
            end
            OP_FLUSH: begin
                if (|hit_vec) begin
                    r_hit = 1'b1;
                    r_way = hit_way;
                    r_ok  = rd_lock[hit_way];
                    r_wb  = rd_dirty[hit_way];
                    r_wba = {tag_q, idx_q, {LINE_BITS{1'b0}}};
                    nv[hit_way] = 1'b0;
                    nl[hit_way] = 1'b0;
                    nd[hit_way] = 1'b0;
                    nu[hit_way] = 1'b0;
                end
            end
            OP_MASK: r_ok = mask_accept;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_ACCESS; src_q <= '0; tag_q <= '0; idx_q <= '0;
            wr_q <= 1'b0; mask_q <= '0;
            wv_q <= '0; wd_q <= '0; wl_q <= '0; wu_q <= '0; wte_q <= '0;
            res_hit_q <= 1'b0; res_way_q <= '0; res_wb_q <= 1'b0; res_wba_q <= '0;
            res_na_q <= 1'b0; res_ok_q <= 1'b0; res_alloc_q <= 1'b0;
            res_blk_q <= '0; res_lck_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            op_q   <= wpv_op_e'(req_op);
            src_q  <= req_src;
            tag_q  <= req_addr[ADDR_W-1 -: TAG_W];
            idx_q  <= req_addr[LINE_BITS +: SET_BITS];
            wr_q   <= req_write;
            mask_q <= req_mask;
        end else if (state_q == ST_LOOK) begin
            wv_q <= nv; wd_q <= nd; wl_q <= nl; wu_q <= nu; wte_q <= nte;
            res_hit_q <= r_hit; res_way_q <= r_way; res_wb_q <= r_wb; res_wba_q <= r_wba;
            res_na_q <= r_na; res_ok_q <= r_ok; res_alloc_q <= r_alloc;
            res_blk_q <= cur_mask; res_lck_q <= rd_lock;
        end
    end

    // Outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        resp_valid   = (state_q == ST_COMMIT);
        resp_hit     = res_hit_q;
        resp_way     = res_way_q;
        resp_wb      = res_wb_q;
        resp_wb_addr = res_wba_q;
        resp_noalloc = res_na_q;
        resp_ok      = res_ok_q;
    end
endmodule

// File: rtl/wpv_checker.sv
module wpv_checker #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             resp_noalloc,
    input logic             resp_wb,
    input logic [WAY_W-1:0] resp_way,
    input logic             alloc_q,
    input logic [WAYS-1:0]  blk_q,
    input logic [WAYS-1:0]  lck_q,
    input logic [WAYS-1:0]  cur_mask
);
    // R10
    resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R10
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 resp_valid);

    // R10
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    // R6
    victim_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && alloc_q) |-> (!blk_q[resp_way] && !lck_q[resp_way]));

    // R6
    noalloc_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_noalloc) |-> (!resp_hit && !resp_wb));

    // R3
    mask_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cur_mask));
endmodule

bind waypart_victim_sel wpv_checker #(.WAYS(WAYS)) u_wpv_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_noalloc(resp_noalloc),
    .resp_wb(resp_wb), .resp_way(resp_way), .alloc_q(res_alloc_q),
    .blk_q(res_blk_q), .lck_q(res_lck_q), .cur_mask(cur_mask)
);

// File: tb/waypart_victim_sel_tb.sv
`timescale 1ns/1ps
module waypart_victim_sel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [1:0]  req_src = '0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_mask = '0;
    logic        resp_valid, resp_hit, resp_wb, resp_noalloc, resp_ok;
    logic [1:0]  resp_way;
    logic [31:0] resp_wb_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    waypart_victim_sel u_dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_src, .req_addr,
        .req_write, .req_mask, .resp_valid, .resp_hit, .resp_way, .resp_wb,
        .resp_wb_addr, .resp_noalloc, .resp_ok
    );

    // {op,src,set,tag,wr,mask, hit,way,wb,na,ok,wbtag,req}
    // op: 0 access, 1 lock, 2 flush, 3 mask write; src 2 = hardware agents
    localparam int NV = 35;
    localparam logic [38:0] VEC [NV] = '{
        {2'd3,2'd0,4'd0,8'd0, 1'b0,4'b1111, 1'b0,2'd0,1'b0,1'b0,1'b0,8'd0, 4'd3},  // R3 reject all-ones
        {2'd3,2'd0,4'd0,8'd0, 1'b0,4'b1100, 1'b0,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd3},  // R3 core0 -> ways 0,1
        {2'd0,2'd0,4'd1,8'd1, 1'b1,4'b0000, 1'b0,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd4},  // R4
        {2'd0,2'd0,4'd1,8'd2, 1'b0,4'b0000, 1'b0,2'd1,1'b0,1'b0,1'b1,8'd0, 4'd4},  // R4
        {2'd0,2'd0,4'd1,8'd3, 1'b0,4'b0000, 1'b0,2'd0,1'b1,1'b0,1'b1,8'd1, 4'd5},  // R5 age, R7 wb
        {2'd0,2'd1,4'd1,8'd4, 1'b0,4'b0000, 1'b0,2'd2,1'b0,1'b0,1'b1,8'd0, 4'd4},  // R4
        {2'd0,2'd1,4'd1,8'd2, 1'b0,4'b0000, 1'b1,2'd1,1'b0,1'b0,1'b1,8'd0, 4'd2},  // R2
        {2'd0,2'd0,4'd1,8'd4, 1'b0,4'b0000, 1'b1,2'd2,1'b0,1'b0,1'b1,8'd0, 4'd2},  // R2 hit in masked way
        {2'd1,2'd0,4'd1,8'd3, 1'b0,4'b0000, 1'b1,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd8},  // R8 granted
        {2'd1,2'd0,4'd1,8'd2, 1'b0,4'b0000, 1'b1,2'd1,1'b0,1'b0,1'b0,8'd0, 4'd8},  // R8 refused
        {2'd0,2'd0,4'd1,8'd5, 1'b0,4'b0000, 1'b0,2'd1,1'b0,1'b0,1'b1,8'd0, 4'd6},  // R6 skip locked
        {2'd3,2'd2,4'd0,8'd0, 1'b0,4'b0111, 1'b0,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd3},  // R3 hw -> way3
        {2'd0,2'd2,4'd1,8'd6, 1'b0,4'b0000, 1'b0,2'd3,1'b0,1'b0,1'b1,8'd0, 4'd4},  // R4
        {2'd0,2'd2,4'd1,8'd7, 1'b0,4'b0000, 1'b0,2'd3,1'b0,1'b0,1'b1,8'd0, 4'd5},  // R5
        {2'd3,2'd0,4'd0,8'd0, 1'b0,4'b1110, 1'b0,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd3},  // R3
        {2'd0,2'd0,4'd1,8'd8, 1'b0,4'b0000, 1'b0,2'd0,1'b0,1'b1,1'b0,8'd0, 4'd6},  // R6 noalloc
        {2'd2,2'd0,4'd1,8'd3, 1'b0,4'b0000, 1'b1,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd9},  // R9 unlock
        {2'd2,2'd0,4'd1,8'd3, 1'b0,4'b0000, 1'b0,2'd0,1'b0,1'b0,1'b0,8'd0, 4'd9},  // R9 miss
        {2'd0,2'd0,4'd1,8'd8, 1'b0,4'b0000, 1'b0,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd9},  // R9 way freed
        {2'd2,2'd0,4'd1,8'd9, 1'b0,4'b0000, 1'b0,2'd0,1'b0,1'b0,1'b0,8'd0, 4'd9},  // R9 miss
        {2'd0,2'd1,4'd2,8'd10,1'b1,4'b0000, 1'b0,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd7},  // R7 dirty fill
        {2'd2,2'd1,4'd2,8'd10,1'b0,4'b0000, 1'b1,2'd0,1'b1,1'b0,1'b0,8'd10,4'd9},  // R9 dirty flush
        {2'd1,2'd1,4'd3,8'd11,1'b0,4'b0000, 1'b0,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd8},  // R8 lock on miss
        {2'd0,2'd1,4'd3,8'd11,1'b0,4'b0000, 1'b1,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd2},  // R2
        {2'd2,2'd1,4'd3,8'd11,1'b0,4'b0000, 1'b1,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd9},  // R9
        {2'd0,2'd1,4'd4,8'd20,1'b1,4'b0000, 1'b0,2'd0,1'b0,1'b0,1'b1,8'd0, 4'd4},  // R4
        {2'd0,2'd1,4'd4,8'd21,1'b0,4'b0000, 1'b0,2'd1,1'b0,1'b0,1'b1,8'd0, 4'd4},  // R4
        {2'd0,2'd1,4'd4,8'd22,1'b0,4'b0000, 1'b0,2'd2,1'b0,1'b0,1'b1,8'd0, 4'd4},  // R4
        {2'd0,2'd1,4'd4,8'd23,1'b0,4'b0000, 1'b0,2'd3,1'b0,1'b0,1'b1,8'd0, 4'd4},  // R4
        {2'd0,2'd1,4'd4,8'd24,1'b0,4'b0000, 1'b0,2'd0,1'b1,1'b0,1'b1,8'd20,4'd7},  // R7 dirty evict
        {2'd0,2'd1,4'd4,8'd25,1'b0,4'b0000, 1'b0,2'd1,1'b0,1'b0,1'b1,8'd0, 4'd5},  // R5 lowest clear
        {2'd1,2'd0,4'd5,8'd30,1'b0,4'b0000, 1'b0,2'd0,1'b0,1'b0,1'b0,8'd0, 4'd8},  // R8 refused on miss
        {2'd1,2'd0,4'd5,8'd30,1'b0,4'b0000, 1'b1,2'd0,1'b0,1'b0,1'b0,8'd0, 4'd8},  // R8 left unlocked
        {2'd3,2'd2,4'd0,8'd0, 1'b0,4'b1111, 1'b0,2'd0,1'b0,1'b0,1'b0,8'd0, 4'd3},  // R3 reject
        {2'd0,2'd2,4'd6,8'd40,1'b0,4'b0000, 1'b0,2'd3,1'b0,1'b0,1'b1,8'd0, 4'd3}   // R3 mask kept
    };

    function automatic logic [31:0] mk_addr(input logic [7:0] tag, input logic [3:0] set);
        return {13'd0, tag, set, 7'd0};
    endfunction

    task automatic chk(input bit good, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [1:0] src, input logic [31:0] addr,
                         input logic wr, input logic [3:0] mask, output int lat, output bit busy_ok);
        @(negedge clk);
        req_op = op; req_src = src; req_addr = addr; req_write = wr; req_mask = mask;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = !req_ready;
        lat = 1;
        while (!resp_valid) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        bit busy;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1, "R1", "ready in reset", 32'(req_ready), 1);
        chk(resp_valid === 1'b0, "R1", "resp_valid in reset", 32'(resp_valid), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [38:0] e;
            string rq;
            e = VEC[i];
            rq = $sformatf("R%0d vec%0d", e[3:0], i);
            do_op(e[38:37], e[36:35], mk_addr(e[30:23], e[34:31]), e[22], e[21:18], lat, busy);
            chk(resp_hit === e[17], rq, "hit", 32'(resp_hit), 32'(e[17]));
            chk(resp_way === e[16:15], rq, "way", 32'(resp_way), 32'(e[16:15]));
            chk(resp_wb === e[14], rq, "wb", 32'(resp_wb), 32'(e[14]));
            chk(resp_noalloc === e[13], rq, "noalloc", 32'(resp_noalloc), 32'(e[13]));
            chk(resp_ok === e[12], rq, "ok", 32'(resp_ok), 32'(e[12]));
            if (e[14])
                chk(resp_wb_addr === mk_addr(e[11:4], e[34:31]), rq, "wb_addr",
                    resp_wb_addr, mk_addr(e[11:4], e[34:31]));
        end

        // R10: handshake and latency
        do_op(2'd0, 2'd1, mk_addr(8'd50, 4'd7), 1'b0, 4'b0, lat, busy);
        chk(lat == 2, "R10", "latency", 32'(lat), 2);
        chk(busy, "R10", "ready low while busy", 32'(!busy), 0);
        chk(resp_way === 2'd0, "R10", "way", 32'(resp_way), 0);
        @(negedge clk);
        chk(resp_valid === 1'b0, "R10", "single-cycle response", 32'(resp_valid), 0);
        chk(req_ready === 1'b1, "R10", "ready after response", 32'(req_ready), 1);

        // R1: reset in the middle clears lines and masks
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && resp_valid === 1'b0, "R1", "idle outputs",
            {30'd0, req_ready, resp_valid}, 32'h2);
        rst_n = 1'b1;
        do_op(2'd0, 2'd0, mk_addr(8'd99, 4'd4), 1'b0, 4'b0, lat, busy);
        chk(resp_hit === 1'b0 && resp_way === 2'd0, "R1", "set4 cleared way",
            {29'd0, resp_hit, resp_way}, 0);
        do_op(2'd0, 2'd0, mk_addr(8'd3, 4'd1), 1'b0, 4'b0, lat, busy);
        chk(resp_hit === 1'b0 && resp_way === 2'd0, "R1", "set1 cleared way",
            {29'd0, resp_hit, resp_way}, 0);
        do_op(2'd0, 2'd0, mk_addr(8'd61, 4'd1), 1'b0, 4'b0, lat, busy);
        chk(resp_way === 2'd1, "R1", "core0 mask cleared", 32'(resp_way), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule